// File: doc/BRIEF.md
# DMA Address Translation Table Walker

This block maps 32-bit DMA addresses from an I/O bus into physical memory addresses. Software places a table of 64-bit translation entries in memory and programs two 64-bit registers: a control register and a table base register. For each translation request, the walker computes the slot of the entry that covers the address, reads that entry through a memory read port, decodes it, and returns a physical address with its access permission or a fault.

The table slot depends on two fields of the control register. One is a granularity bit that selects 8 KiB or 64 KiB table pages. The other is a 3-bit size code that sets how many address bits index the table. The fetched entry then sets its own page size. When translation is turned off, every address passes through unchanged with full read/write access. The block handles one request at a time and signals busy while a table read is outstanding.

Top module: `dma_xlate_walker`

## Requirements
- R1: After reset, both registers read zero, and `xl_busy`, `xl_rsp_valid` and `mem_req` are low.
- R2: Register offsets: control at 0x00, base at 0x08. A 64-bit access (`reg_wide`=1) at the offset covers the whole register. A 32-bit access at the offset covers bits 63:32, and any access at offset+4 covers bits 31:0. Reads return the half in `reg_rdata[31:0]`, and writes keep the other half. Offsets 0x18 to 0x1F and unaligned offsets read zero and ignore writes.
- R3: Offsets 0x10 and 0x14 form a flush register. It always reads zero, and writes to it change no state.
- R4: Control bit 0 enables translation, control bit 2 selects 64 KiB table granularity, and control bits 18:16 hold the size code n. All other control bits have no effect.
- R5: With translation disabled, a request is answered in the cycle after it is accepted, with no memory read. The response has fault=0, permission 2'b11 (read/write), page64=0, and a physical address equal to the request address zero-extended to 41 bits.
- R6: With 8 KiB granularity, the entry is read at base + ((addr & bits 22+n..13) >> 10), for n from 0 to 7.
- R7: With 64 KiB granularity, the entry is read at base + ((addr & bits 25+n..16) >> 13), for n from 0 to 5. Size codes 6 and 7 give a fault response with permission 2'b00 in the cycle after acceptance, with no memory read.
- R8: `mem_data` holds the eight entry bytes with the lowest-addressed byte in bits 63:56, and the block uses it as a big-endian number. Entry bit 63 means valid. An entry with bit 63 clear gives fault=1, permission 2'b00 and a zero physical address.
- R9: For a valid entry, bit 1 set gives permission 2'b11, and bit 1 clear gives 2'b01 (read-only). If entry bit 61 is clear, the physical address is {entry[40:13], addr[12:0]} with page64=0. If bit 61 is set, it is {entry[40:16], addr[15:0]} with page64=1.
- R10: The walker accepts a request while `xl_busy` is low. `xl_busy` and `mem_req` rise in the cycle after a table-reading request is accepted. `mem_req` and `mem_addr` then hold until `mem_valid`. The response appears as a one-cycle `xl_rsp_valid` in the cycle after `mem_valid`. Requests raised while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| reg_rdata | output | 64 | Read data for `reg_addr` (combinational) |
| xl_req | input | 1 | Translation request |
| xl_addr | input | 32 | DMA address to translate |
| xl_busy | output | 1 | Table read in progress; requests ignored |
| xl_rsp_valid | output | 1 | One-cycle response strobe |
| xl_rsp_fault | output | 1 | Translation failed |
| xl_rsp_perm | output | 2 | 00 none, 01 read-only, 11 read/write |
| xl_rsp_page64 | output | 1 | Translation uses a 64 KiB page |
| xl_rsp_pa | output | 41 | Physical address |
| mem_req | output | 1 | Entry read request |
| mem_addr | output | 64 | Entry byte address |
| mem_valid | input | 1 | Entry data returned |
| mem_data | input | 64 | Entry data, big-endian |

## Verification
The bench sweeps every size code in both granularities, using addresses with bits set above the index field. A design with an off-by-one mask would fetch from the wrong slot. The unsupported 64 KiB codes and the disabled case must answer without touching memory. A design that still read memory would raise `mem_req`. The half-register accesses are checked on both halves to catch swapped upper and lower words. Page sizes are covered in both directions to catch an offset taken from the entry instead of the address, and a competing request is held during a slow fetch to catch a design that restarts or retargets the walk.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W  = 32;
  localparam int PA_W  = 41;
  localparam int ENT_W = 64;
  localparam int REG_W = 64;
  localparam int MA_W  = 64;
  localparam int RA_W  = 5;

  localparam int CTL_EN   = 0;
  localparam int CTL_G64  = 2;
  localparam int CTL_SZ   = 16;
  localparam int ENT_VLD  = 63;
  localparam int ENT_BIG  = 61;
  localparam int ENT_WR   = 1;
  localparam int PG8_SH   = 13;
  localparam int PG64_SH  = 16;
  localparam int SZ_MAX64 = 5;

  typedef enum logic [1:0] {
    PERM_NONE = 2'b00,
    PERM_RO   = 2'b01,
    PERM_RW   = 2'b11
  } perm_e;

  typedef enum logic {ST_IDLE, ST_FETCH} walk_st_e;

  typedef struct packed {
    logic            fault;
    perm_e           perm;
    logic            page64;
    logic [PA_W-1:0] pa;
  } xl_rsp_t;
endpackage

// File: rtl/xw_regs.sv
module xw_regs
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_wide,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] ctrl_o,
  output logic [REG_W-1:0] base_o
);
  localparam int HALF = REG_W / 2;

  logic [REG_W-1:0] ctrl_q, ctrl_d, base_q, base_d;
  logic             ctrl_en, base_en;
  logic             aligned, sel_ctl, sel_base, lo_half;

  function automatic logic [REG_W-1:0] merge_wr(input logic [REG_W-1:0] old,
                                                input logic [REG_W-1:0] wd,
                                                input logic wide, input logic lo);
    if (lo)        return {old[REG_W-1:HALF], wd[HALF-1:0]};
    else if (wide) return wd;
    else           return {wd[HALF-1:0], old[HALF-1:0]};
  endfunction

  function automatic logic [REG_W-1:0] pick_rd(input logic [REG_W-1:0] q,
                                               input logic wide, input logic lo);
    if (lo)        return {{HALF{1'b0}}, q[HALF-1:0]};
    else if (wide) return q;
    else           return {{HALF{1'b0}}, q[REG_W-1:HALF]};
  endfunction

  always_comb begin
    aligned  = (reg_addr[1:0] == 2'b00);
    sel_ctl  = aligned && (reg_addr[4:3] == 2'b00);
    sel_base = aligned && (reg_addr[4:3] == 2'b01);
    lo_half  = reg_addr[2];
    ctrl_en  = reg_wr && sel_ctl;
    base_en  = reg_wr && sel_base;
    ctrl_d   = merge_wr(ctrl_q, reg_wdata, reg_wide, lo_half);
    base_d   = merge_wr(base_q, reg_wdata, reg_wide, lo_half);
    if (sel_ctl)       reg_rdata = pick_rd(ctrl_q, reg_wide, lo_half);
    else if (sel_base) reg_rdata = pick_rd(base_q, reg_wide, lo_half);
    else               reg_rdata = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
    end else begin
      if (ctrl_en) ctrl_q <= ctrl_d;
      if (base_en) base_q <= base_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign base_o = base_q;
endmodule

// File: rtl/xw_index.sv
module xw_index
  import xw_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  logic [MA_W-1:0] base,
  input  logic            gran64,
  input  logic [2:0]      size_code,
  output logic [MA_W-1:0] ent_addr,
  output logic            size_bad
);
  localparam int IDX8_W  = VA_W - 2 - PG8_SH;   // bits 29..13
  localparam int IDX64_W = VA_W - 1 - PG64_SH;  // bits 30..16
  localparam int OFF_W   = IDX8_W + 3;

  logic [IDX8_W-1:0]  idx8;
  logic [IDX64_W-1:0] idx64;
  logic [OFF_W-1:0]   off;
  logic [4:0]         keep;
  logic               unused_va;

  always_comb begin
    keep     = 5'd10 + {2'b00, size_code};
    idx8     = va[PG8_SH+IDX8_W-1:PG8_SH] & ((IDX8_W'(1) << keep) - IDX8_W'(1));
    idx64    = va[PG64_SH+IDX64_W-1:PG64_SH] & ((IDX64_W'(1) << keep) - IDX64_W'(1));
    size_bad = gran64 && (size_code > 3'(SZ_MAX64));
    if (gran64) off = {{(OFF_W-IDX64_W-3){1'b0}}, idx64, 3'b000};
    else        off = {idx8, 3'b000};
    ent_addr = base + {{(MA_W-OFF_W){1'b0}}, off};
  end

  assign unused_va = ^{va[VA_W-1], va[PG8_SH-1:0]};
endmodule

// File: rtl/xw_decode.sv
module xw_decode
  import xw_pkg::*;
(
  input  logic [ENT_W-1:0] entry,
  input  logic [VA_W-1:0]  va,
  output xl_rsp_t          rsp
);
  logic unused_ent;

  always_comb begin
    rsp.fault  = 1'b1;
    rsp.perm   = PERM_NONE;
    rsp.page64 = 1'b0;
    rsp.pa     = '0;
    if (entry[ENT_VLD]) begin
      rsp.fault  = 1'b0;
      rsp.perm   = entry[ENT_WR] ? PERM_RW : PERM_RO;
      rsp.page64 = entry[ENT_BIG];
      if (entry[ENT_BIG])
        rsp.pa = {entry[PA_W-1:PG64_SH], va[PG64_SH-1:0]};
      else
        rsp.pa = {entry[PA_W-1:PG8_SH], va[PG8_SH-1:0]};
    end
  end

  assign unused_ent = ^{entry[62], entry[60:PA_W], entry[PG8_SH-1:2], entry[0],
                        va[VA_W-1:PG64_SH]};
endmodule

// File: rtl/dma_xlate_walker.sv
module dma_xlate_walker
  import xw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_wide,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             xl_req,
  input  logic [VA_W-1:0]  xl_addr,
  output logic             xl_busy,
  output logic             xl_rsp_valid,
  output logic             xl_rsp_fault,
  output logic [1:0]       xl_rsp_perm,
  output logic             xl_rsp_page64,
  output logic [PA_W-1:0]  xl_rsp_pa,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_valid,
  input  logic [ENT_W-1:0] mem_data
);
  logic [REG_W-1:0] ctrl_w, base_w;
  logic [MA_W-1:0]  ent_addr_w;
  logic             size_bad_w;
  xl_rsp_t          dec_rsp_w;

  walk_st_e         state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [MA_W-1:0]  maddr_q;
  xl_rsp_t          rsp_q, rsp_d;
  logic             rsp_vld_q, rsp_vld_d;
  logic             va_en, maddr_en, rsp_en;
  logic             unused_ctrl;

  xw_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_wide  (reg_wide),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ctrl_o    (ctrl_w),
    .base_o    (base_w)
  );

  xw_index u_index (
    .va        (xl_addr),
    .base      (base_w),
    .gran64    (ctrl_w[CTL_G64]),
    .size_code (ctrl_w[CTL_SZ+2:CTL_SZ]),
    .ent_addr  (ent_addr_w),
    .size_bad  (size_bad_w)
  );

  xw_decode u_decode (
    .entry (mem_data),
    .va    (va_q),
    .rsp   (dec_rsp_w)
  );

  always_comb begin
    state_d   = state_q;
    va_en     = 1'b0;
    maddr_en  = 1'b0;
    rsp_en    = 1'b0;
    rsp_vld_d = 1'b0;
    rsp_d.fault  = 1'b0;
    rsp_d.perm   = PERM_NONE;
    rsp_d.page64 = 1'b0;
    rsp_d.pa     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (xl_req) begin
          va_en = 1'b1;
          if (!ctrl_w[CTL_EN]) begin
            rsp_en    = 1'b1;
            rsp_vld_d = 1'b1;
            rsp_d.perm = PERM_RW;
            rsp_d.pa   = {{(PA_W-VA_W){1'b0}}, xl_addr};
          end else if (size_bad_w) begin
            rsp_en      = 1'b1;
            rsp_vld_d   = 1'b1;
            rsp_d.fault = 1'b1;
          end else begin
            maddr_en = 1'b1;
            state_d  = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (mem_valid) begin
          rsp_en    = 1'b1;
          rsp_vld_d = 1'b1;
          rsp_d     = dec_rsp_w;
          state_d   = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      va_q      <= '0;
      maddr_q   <= '0;
      rsp_q     <= '0;
      rsp_vld_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_vld_q <= rsp_vld_d;
      if (va_en)    va_q    <= xl_addr;
      if (maddr_en) maddr_q <= ent_addr_w;
      if (rsp_en)   rsp_q   <= rsp_d;
    end
  end

  assign xl_busy       = (state_q == ST_FETCH);
  assign mem_req       = (state_q == ST_FETCH);
  assign mem_addr      = maddr_q;
  assign xl_rsp_valid  = rsp_vld_q;
  assign xl_rsp_fault  = rsp_q.fault;
  assign xl_rsp_perm   = rsp_q.perm;
  assign xl_rsp_page64 = rsp_q.page64;
  assign xl_rsp_pa     = rsp_q.pa;
  assign unused_ctrl   = ^{ctrl_w[REG_W-1:CTL_SZ+3], ctrl_w[CTL_SZ-1:CTL_G64+1], ctrl_w[1]};
endmodule

// File: rtl/xw_chk.sv
module xw_chk
  import xw_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             xl_busy,
  input logic             mem_req,
  input logic             mem_valid,
  input logic [MA_W-1:0]  mem_addr,
  input logic             xl_rsp_valid,
  input logic             xl_rsp_fault,
  input logic [1:0]       xl_rsp_perm,
  input logic [PA_W-1:0]  xl_rsp_pa,
  input logic [RA_W-1:0]  reg_addr,
  input logic [REG_W-1:0] reg_rdata
);
  // R10
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr));

  // R10
  busy_during_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> xl_busy);

  // R10
  rsp_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_valid |=> xl_rsp_valid && !mem_req);

  // R8
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp_valid && xl_rsp_fault |-> xl_rsp_perm == 2'b00 && xl_rsp_pa == '0);

  // R9
  perm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_rsp_valid && !xl_rsp_fault |-> xl_rsp_perm == 2'b01 || xl_rsp_perm == 2'b11);

  // R3
  flush_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr[4:3] == 2'b10 |-> reg_rdata == '0);
endmodule

bind dma_xlate_walker xw_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .xl_busy      (xl_busy),
  .mem_req      (mem_req),
  .mem_valid    (mem_valid),
  .mem_addr     (mem_addr),
  .xl_rsp_valid (xl_rsp_valid),
  .xl_rsp_fault (xl_rsp_fault),
  .xl_rsp_perm  (xl_rsp_perm),
  .xl_rsp_pa    (xl_rsp_pa),
  .reg_addr     (reg_addr),
  .reg_rdata    (reg_rdata)
);

// File: tb/test_dma_xlate_walker.sv
module test_dma_xlate_walker;
  logic        clk, rst_n;
  logic        reg_wr, reg_wide;
  logic [4:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        xl_req;
  logic [31:0] xl_addr;
  logic        xl_busy, xl_rsp_valid, xl_rsp_fault, xl_rsp_page64;
  logic [1:0]  xl_rsp_perm;
  logic [40:0] xl_rsp_pa;
  logic        mem_req, mem_valid;
  logic [63:0] mem_addr, mem_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  dma_xlate_walker i_dma_xlate_walker (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xl_req(xl_req), .xl_addr(xl_addr), .xl_busy(xl_busy),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_fault(xl_rsp_fault),
    .xl_rsp_perm(xl_rsp_perm), .xl_rsp_page64(xl_rsp_page64),
    .xl_rsp_pa(xl_rsp_pa), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_valid(mem_valid), .mem_data(mem_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input bit wide, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wide = wide; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, input bit wide, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wide = wide;
    #1 d = reg_rdata;
  endtask

  function automatic logic [63:0] exp_eaddr(input logic [63:0] base, input bit g64,
                                            input int n, input logic [31:0] va);
    logic [63:0] m;
    if (g64) begin
      m = ((64'd1 << (26 + n)) - 64'd1) & ~64'hFFFF;
      return base + ((({32'd0, va}) & m) >> 13);
    end
    m = ((64'd1 << (23 + n)) - 64'd1) & ~64'h1FFF;
    return base + ((({32'd0, va}) & m) >> 10);
  endfunction

  function automatic logic [63:0] exp_pa(input logic [63:0] e, input logic [31:0] va);
    if (e[61]) return (e & 64'h1FFFFFF8000 & ~64'hFFFF) | ({32'd0, va} & 64'hFFFF);
    return (e & 64'h1FFFFFFE000) | ({32'd0, va} & 64'h1FFF);
  endfunction

  // one translation; serves the memory read after lat idle cycles if one is raised
  task automatic run_xl(input logic [31:0] va, input logic [63:0] entry, input int lat,
                        output bit fetched, output logic [63:0] maddr, output bit rv);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = va;
    @(negedge clk);
    xl_req = 1'b0;
    fetched = 1'b0;
    maddr = '0;
    if (mem_req) begin
      fetched = 1'b1;
      maddr = mem_addr;
      repeat (lat) @(negedge clk);
      mem_valid = 1'b1; mem_data = entry;
      @(negedge clk);
      mem_valid = 1'b0;
    end
    rv = xl_rsp_valid;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    chk("R1 busy", {63'd0, xl_busy}, 64'd0);
    chk("R1 rsp_valid", {63'd0, xl_rsp_valid}, 64'd0);
    chk("R1 mem_req", {63'd0, mem_req}, 64'd0);
    reg_read(5'h00, 1'b1, d); chk("R1 ctrl", d, 64'd0);
    reg_read(5'h08, 1'b1, d); chk("R1 base", d, 64'd0);
  endtask

  task automatic t_regs;
    logic [63:0] d;
    reg_write(5'h08, 1'b1, 64'h1122_3344_5566_7788);
    reg_read(5'h08, 1'b1, d); chk("R2 base wide", d, 64'h1122_3344_5566_7788);
    reg_read(5'h08, 1'b0, d); chk("R2 base upper", d, 64'h1122_3344);
    reg_read(5'h0C, 1'b0, d); chk("R2 base lower", d, 64'h5566_7788);
    reg_write(5'h0C, 1'b0, 64'hFFFF_FFFF_AABB_CCDD);
    reg_read(5'h08, 1'b1, d); chk("R2 lower write", d, 64'h1122_3344_AABB_CCDD);
    reg_write(5'h08, 1'b0, 64'h0000_0000_0102_0304);
    reg_read(5'h08, 1'b1, d); chk("R2 upper write", d, 64'h0102_0304_AABB_CCDD);
    reg_write(5'h04, 1'b0, 64'h0000_0000_0007_0004);
    reg_read(5'h00, 1'b1, d); chk("R2 ctrl lower", d, 64'h0000_0000_0007_0004);
    reg_write(5'h18, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_write(5'h09, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_read(5'h18, 1'b1, d); chk("R2 undecoded read", d, 64'd0);
    reg_read(5'h08, 1'b1, d); chk("R2 undecoded write", d, 64'h0102_0304_AABB_CCDD);
  endtask

  task automatic t_flush;
    logic [63:0] d;
    reg_write(5'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_write(5'h14, 1'b0, 64'hFFFF_FFFF);
    reg_read(5'h10, 1'b1, d); chk("R3 flush read", d, 64'd0);
    reg_read(5'h14, 1'b0, d); chk("R3 flush lower", d, 64'd0);
    reg_read(5'h00, 1'b1, d); chk("R3 ctrl kept", d, 64'h0000_0000_0007_0004);
    reg_read(5'h08, 1'b1, d); chk("R3 base kept", d, 64'h0102_0304_AABB_CCDD);
  endtask

  task automatic t_pass;
    bit f, rv; logic [63:0] ma;
    // R4: enable clear; granularity and size bits set but ignored
    reg_write(5'h00, 1'b1, 64'hFFFF_0000_0007_0004);
    run_xl(32'hDEAD_BEEF, 64'd0, 0, f, ma, rv);
    chk("R5 no fetch", {63'd0, f}, 64'd0);
    chk("R5 valid", {63'd0, rv}, 64'd1);
    chk("R5 pa", {23'd0, xl_rsp_pa}, 64'hDEAD_BEEF);
    chk("R5 perm", {62'd0, xl_rsp_perm}, 64'd3);
    chk("R5 fault", {62'd0, xl_rsp_page64, xl_rsp_fault}, 64'd0);
    @(negedge clk);
    chk("R10 single pulse", {63'd0, xl_rsp_valid}, 64'd0);
  endtask

  task automatic t_idx8;
    bit f, rv; logic [63:0] ma;
    logic [63:0] base = 64'h0000_0040_0000_8000;
    logic [63:0] ent  = 64'h8000_0123_4567_A002;
    reg_write(5'h08, 1'b1, base);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] va = (n % 2 == 0) ? 32'h7FFF_F123 : 32'hA5A5_5A5A;
      reg_write(5'h00, 1'b1, {45'd0, 3'(n), 16'h0001});
      run_xl(va, ent, n % 3, f, ma, rv);
      chk("R6 fetch", {63'd0, f}, 64'd1);
      chk("R6 entry addr", ma, exp_eaddr(base, 1'b0, n, va));
      chk("R9 valid", {63'd0, rv}, 64'd1);
      chk("R9 pa 8K", {23'd0, xl_rsp_pa}, exp_pa(ent, va));
      chk("R9 perm rw", {62'd0, xl_rsp_perm}, 64'd3);
      chk("R9 page64", {62'd0, xl_rsp_page64, xl_rsp_fault}, 64'd0);
    end
  endtask

  task automatic t_idx64;
    bit f, rv; logic [63:0] ma;
    logic [63:0] base = 64'h0000_0001_2340_0000;
    logic [63:0] ent  = 64'hA000_01AB_CDEF_8000;
    reg_write(5'h08, 1'b1, base);
    for (int n = 0; n < 8; n++) begin
      logic [31:0] va = 32'hFFFF_ABCD ^ (32'h1 << (16 + n));
      // R4: bit 2 picks 64K table granularity, bits 18:16 the size code
      reg_write(5'h00, 1'b1, {45'd0, 3'(n), 16'h0005});
      run_xl(va, ent, 1, f, ma, rv);
      chk("R7 valid", {63'd0, rv}, 64'd1);
      if (n <= 5) begin
        chk("R7 fetch", {63'd0, f}, 64'd1);
        chk("R7 entry addr", ma, exp_eaddr(base, 1'b1, n, va));
        chk("R9 pa 64K", {23'd0, xl_rsp_pa}, exp_pa(ent, va));
        chk("R9 perm ro", {62'd0, xl_rsp_perm}, 64'd1);
        chk("R9 page64 set", {62'd0, xl_rsp_page64, xl_rsp_fault}, 64'd2);
      end else begin
        chk("R7 bad size no fetch", {63'd0, f}, 64'd0);
        chk("R7 bad size fault", {63'd0, xl_rsp_fault}, 64'd1);
        chk("R7 bad size perm", {62'd0, xl_rsp_perm}, 64'd0);
      end
    end
  endtask

  task automatic t_invalid;
    bit f, rv; logic [63:0] ma;
    reg_write(5'h00, 1'b1, 64'h0000_0000_0003_0001);
    run_xl(32'h1234_5678, 64'h6000_01FF_FFFF_E002, 2, f, ma, rv);
    chk("R8 fetch", {63'd0, f}, 64'd1);
    chk("R8 valid", {63'd0, rv}, 64'd1);
    chk("R8 fault", {63'd0, xl_rsp_fault}, 64'd1);
    chk("R8 perm none", {62'd0, xl_rsp_perm}, 64'd0);
    chk("R8 pa zero", {23'd0, xl_rsp_pa}, 64'd0);
  endtask

  task automatic t_busy;
    logic [63:0] a0;
    logic [63:0] base = 64'h0000_0000_0010_0000;
    logic [63:0] ent  = 64'h8000_0000_0ABC_E002;
    reg_write(5'h08, 1'b1, base);
    reg_write(5'h00, 1'b1, 64'h0000_0000_0002_0001);
    @(negedge clk);
    xl_req = 1'b1; xl_addr = 32'h0012_3456;
    @(negedge clk);
    chk("R10 busy", {62'd0, xl_busy, mem_req}, 64'd3);
    a0 = mem_addr;
    chk("R10 addr", a0, exp_eaddr(base, 1'b0, 2, 32'h0012_3456));
    xl_addr = 32'h0076_5432;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 held", mem_addr, a0);
      chk("R10 still busy", {62'd0, xl_busy, xl_rsp_valid}, 64'd2);
    end
    xl_req = 1'b0;
    mem_valid = 1'b1; mem_data = ent;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R10 rsp", {63'd0, xl_rsp_valid}, 64'd1);
    chk("R10 first va", {23'd0, xl_rsp_pa}, exp_pa(ent, 32'h0012_3456));
    @(negedge clk);
    chk("R10 idle", {62'd0, xl_rsp_valid, mem_req}, 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wide = 1'b0; reg_addr = '0; reg_wdata = '0;
    xl_req = 1'b0; xl_addr = '0; mem_valid = 1'b0; mem_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_flush;
    t_pass;
    t_idx8;
    t_idx64;
    t_invalid;
    t_busy;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule